// File: doc/BRIEF.md
# Custom Control-Register Access Unit

This unit answers control and status register requests from a processor pipeline. Each request carries a 12-bit register address, an operation (plain read, replace, bit set or bit clear), a 32-bit operand and the privilege level of the requester. The unit works out from the address alone whether the register may be written and which privilege it needs. It then returns the register contents and an illegal-access flag in the same cycle, and commits any legal update at the next rising clock edge.

Behind the address decode sit a few machine-level registers. A 32-bit count of retired instructions advances on a retire strobe. A free-running 32-bit clock-cycle count advances every cycle. A general-purpose I/O port has a drive-value register, a per-bit drive-enable register and a view of the sampled pin inputs. Two further addresses exist only for their side effects on the retired-instruction count: one clears it and one loads a fixed preset into it. The pins are presented as separate drive-value, drive-enable and input buses, and a pad ring builds the three-state buffers from them.

Top module: `csr_custom_unit`

## Requirements
- R1: When address bits [11:10] equal 2'b11 the register is read-only, and any write intent to such an address raises `illegal` and changes no state. Address values 00, 01 and 10 in those bits mark writable space.
- R2: Address bits [9:8] give the lowest privilege allowed to access the register (`req_priv` encoding: 00 user, 01 supervisor, 11 machine). A request from a numerically lower privilege raises `illegal`.
- R3: `req_op` encoding: 00 read, 01 replace with operand, 10 OR operand in, 11 AND with inverted operand. Set or clear with an all-zero operand counts as a read only and never raises a write violation.
- R4: Address 0xB04 holds a writable 32-bit retired-instruction count that advances by one at each clock edge where `retire` is high.
- R5: Address 0xB05 returns a 32-bit clock-cycle count that advances by one every clock edge. Any write intent to it is illegal.
- R6: Write intent to 0xB06 clears the retired-instruction count to zero. Any legal access to 0xB07 loads it with 0x40000000. Both addresses read as zero.
- R7: Address 0xB08 holds the 32-bit GPIO drive value (driven on `gpio_out`) and 0xB09 the per-bit drive enable (driven on `gpio_oe`). Address 0xB0A returns `gpio_in` and is read-only.
- R8: A legal software write to 0xB04 in the same cycle as a retire strobe wins: the count takes the written value.
- R9: An address outside the implemented set raises `illegal`. Whenever a request is illegal, `rd_data` is zero and no register or side effect changes.
- R10: Reset clears all registers to zero. `rd_data` and `illegal` follow the request inputs in the same cycle, and updates take effect at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 set, 11 clear |
| req_wdata | input | 32 | Write value or bit mask |
| req_priv | input | 2 | Privilege of the requester |
| retire | input | 1 | One instruction retired this cycle |
| gpio_in | input | 32 | Sampled pin levels |
| rd_data | output | 32 | Register contents before the update |
| illegal | output | 1 | Request violates permission or address |
| gpio_out | output | 32 | Pin drive values |
| gpio_oe | output | 32 | Pin drive enables |

## Verification
`rd_data` and `illegal` are due in the cycle the request is presented. The bench therefore drives each request at the falling edge and samples these two outputs one nanosecond later, before the next rising edge. Register contents, `gpio_out` and `gpio_oe` change at the rising edge that ends the request cycle. They are checked by a read, or by sampling the pins, in the following half-period. The cycle counter is checked as the difference between two reads taken a known number of edges apart, so the absolute reset timing does not matter.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLEAR = 2'b11
  } csr_op_e;

  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_RETIRED  = 12'hB04;
  localparam logic [ADDR_W-1:0] A_TICKS    = 12'hB05;
  localparam logic [ADDR_W-1:0] A_RET_ZERO = 12'hB06;
  localparam logic [ADDR_W-1:0] A_RET_LOAD = 12'hB07;
  localparam logic [ADDR_W-1:0] A_PIN_VAL  = 12'hB08;
  localparam logic [ADDR_W-1:0] A_PIN_DRV  = 12'hB09;
  localparam logic [ADDR_W-1:0] A_PIN_SMP  = 12'hB0A;
endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
  import csr_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        priv,
  output logic              wr_intent,
  output logic              bad
);
  localparam int RO_HI   = ADDR_W - 1;
  localparam int PRIV_HI = ADDR_W - 3;

  logic known, read_only, priv_low;

  always_comb begin
    // zero-mask set/clear is a pure read
    wr_intent = (op == OP_WRITE) || ((op == OP_SET || op == OP_CLEAR) && (|operand));
    read_only = (addr[RO_HI -: 2] == 2'b11) || (addr == A_TICKS) || (addr == A_PIN_SMP);
    priv_low  = priv < addr[PRIV_HI -: 2];
    known     = (addr == A_RETIRED)  || (addr == A_TICKS)   || (addr == A_RET_ZERO) ||
                (addr == A_RET_LOAD) || (addr == A_PIN_VAL) || (addr == A_PIN_DRV)  ||
                (addr == A_PIN_SMP);
    bad       = !known || priv_low || (read_only && wr_intent);
  end
endmodule

// File: rtl/csr_counter_bank.sv
module csr_counter_bank #(
  parameter int              W      = 32,
  parameter logic [W-1:0]    PRESET = 32'h4000_0000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         retire,
  input  logic         sw_wr,
  input  logic [W-1:0] sw_val,
  input  logic         zero_req,
  input  logic         load_req,
  output logic [W-1:0] retired_q,
  output logic [W-1:0] ticks_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      retired_q <= '0;
      ticks_q   <= '0;
    end else begin
      ticks_q <= ticks_q + 1'b1;
      if (sw_wr)         retired_q <= sw_val;   // software beats retire
      else if (zero_req) retired_q <= '0;
      else if (load_req) retired_q <= PRESET;
      else if (retire)   retired_q <= retired_q + 1'b1;
    end
  end
endmodule

// File: rtl/csr_pin_bank.sv
module csr_pin_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         val_wr,
  input  logic         drv_wr,
  input  logic [W-1:0] new_val,
  output logic [W-1:0] val_q,
  output logic [W-1:0] drv_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      drv_q <= '0;
    end else begin
      if (val_wr) val_q <= new_val;
      if (drv_wr) drv_q <= new_val;
    end
  end
endmodule

// File: rtl/csr_custom_unit.sv
module csr_custom_unit
  import csr_unit_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_priv,
  input  logic              retire,
  input  logic [DATA_W-1:0] gpio_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              illegal,
  output logic [DATA_W-1:0] gpio_out,
  output logic [DATA_W-1:0] gpio_oe
);
  logic              wr_intent, bad, legal, do_wr;
  logic [DATA_W-1:0] cur, new_val;
  logic [DATA_W-1:0] retired_q, ticks_q, pin_val_q, pin_drv_q;

  csr_access_check #(.DATA_W(DATA_W)) u_check (
    .addr(req_addr), .op(req_op), .operand(req_wdata), .priv(req_priv),
    .wr_intent(wr_intent), .bad(bad)
  );

  always_comb begin
    case (req_addr)
      A_RETIRED: cur = retired_q;
      A_TICKS:   cur = ticks_q;
      A_PIN_VAL: cur = pin_val_q;
      A_PIN_DRV: cur = pin_drv_q;
      A_PIN_SMP: cur = gpio_in;
      default:   cur = '0;
    endcase
    case (req_op)
      OP_WRITE: new_val = req_wdata;
      OP_SET:   new_val = cur | req_wdata;
      OP_CLEAR: new_val = cur & ~req_wdata;
      default:  new_val = cur;
    endcase
  end

  assign rd_data = bad ? '0 : cur;
  assign illegal = req_valid & bad;
  assign legal   = req_valid & ~bad;
  assign do_wr   = legal & wr_intent;

  csr_counter_bank #(.W(DATA_W), .PRESET(DATA_W'(32'h4000_0000))) u_counters (
    .clk(clk), .rst(rst), .retire(retire),
    .sw_wr(do_wr && req_addr == A_RETIRED), .sw_val(new_val),
    .zero_req(do_wr && req_addr == A_RET_ZERO),
    .load_req(legal && req_addr == A_RET_LOAD),
    .retired_q(retired_q), .ticks_q(ticks_q)
  );

  csr_pin_bank #(.W(DATA_W)) u_pins (
    .clk(clk), .rst(rst),
    .val_wr(do_wr && req_addr == A_PIN_VAL),
    .drv_wr(do_wr && req_addr == A_PIN_DRV),
    .new_val(new_val), .val_q(pin_val_q), .drv_q(pin_drv_q)
  );

  assign gpio_out = pin_val_q;
  assign gpio_oe  = pin_drv_q;
endmodule

// File: rtl/csr_custom_unit_chk.sv
module csr_custom_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         req_valid,
  input logic [11:0]  req_addr,
  input logic [1:0]   req_op,
  input logic [W-1:0] req_wdata,
  input logic [1:0]   req_priv,
  input logic         retire,
  input logic [W-1:0] rd_data,
  input logic         illegal,
  input logic [W-1:0] gpio_out,
  input logic [W-1:0] gpio_oe,
  input logic [W-1:0] retired_q,
  input logic [W-1:0] ticks_q
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_ro_write_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_addr[11:10] == 2'b11 && req_op == 2'b01 |-> illegal);

  assert_priv_floor_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_priv < req_addr[9:8]) |-> illegal);

  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op[1] && req_wdata == '0 && req_addr == 12'hB05 && req_priv == 2'b11
    |-> !illegal);

  assert_retire_step_R4: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(retire) && !$past(req_valid) |-> retired_q == $past(retired_q) + 1'b1);

  assert_tick_step_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> ticks_q == $past(ticks_q) + 1'b1);

  assert_sw_wins_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && !illegal && req_addr == 12'hB04 && req_op == 2'b01
    |=> retired_q == $past(req_wdata));

  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> rd_data == '0);

  assert_illegal_nochange_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid && illegal |=> $stable(gpio_out) && $stable(gpio_oe));
endmodule

bind csr_custom_unit csr_custom_unit_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_op(req_op), .req_wdata(req_wdata), .req_priv(req_priv), .retire(retire),
  .rd_data(rd_data), .illegal(illegal), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
  .retired_q(retired_q), .ticks_q(ticks_q)
);

// File: tb/tb_csr_custom_unit.sv
`timescale 1ns/1ps
module tb_csr_custom_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_priv = 2'b11;
  logic        retire = 1'b0;
  logic [31:0] gpio_in = 32'h1234_5678;
  logic [31:0] rd_data, gpio_out, gpio_oe;
  logic        illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csr_custom_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_wdata(req_wdata), .req_priv(req_priv), .retire(retire),
    .gpio_in(gpio_in), .rd_data(rd_data), .illegal(illegal),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe)
  );

  // {addr, op, priv, wdata, exp_illegal, check_rd, exp_rd}
  localparam int NV = 17;
  localparam logic [81:0] VEC [NV] = '{
    {12'hB08, 2'b01, 2'b11, 32'hA5A5_0000, 1'b0, 1'b1, 32'h0000_0000},
    {12'hB08, 2'b00, 2'b11, 32'h0000_0000, 1'b0, 1'b1, 32'hA5A5_0000},
    {12'hB08, 2'b10, 2'b11, 32'h0000_00FF, 1'b0, 1'b1, 32'hA5A5_0000},
    {12'hB08, 2'b11, 2'b11, 32'hA000_0000, 1'b0, 1'b1, 32'hA5A5_00FF},
    {12'hB08, 2'b00, 2'b11, 32'h0000_0000, 1'b0, 1'b1, 32'h05A5_00FF},
    {12'hB08, 2'b01, 2'b00, 32'hFFFF_FFFF, 1'b1, 1'b1, 32'h0000_0000},
    {12'hB08, 2'b00, 2'b11, 32'h0000_0000, 1'b0, 1'b1, 32'h05A5_00FF},
    {12'hB09, 2'b01, 2'b01, 32'h0F0F_0F0F, 1'b1, 1'b1, 32'h0000_0000},
    {12'hB09, 2'b01, 2'b11, 32'h0F0F_0F0F, 1'b0, 1'b1, 32'h0000_0000},
    {12'hB09, 2'b00, 2'b11, 32'h0000_0000, 1'b0, 1'b1, 32'h0F0F_0F0F},
    {12'hB0A, 2'b01, 2'b11, 32'h0000_0001, 1'b1, 1'b1, 32'h0000_0000},
    {12'hB05, 2'b01, 2'b11, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000},
    {12'hB05, 2'b10, 2'b11, 32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000},
    {12'hC00, 2'b01, 2'b11, 32'h0000_0001, 1'b1, 1'b1, 32'h0000_0000},
    {12'h123, 2'b00, 2'b00, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000},
    {12'hB0A, 2'b11, 2'b11, 32'h0000_0000, 1'b0, 1'b1, 32'h1234_5678},
    {12'hB0A, 2'b00, 2'b01, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(input logic [11:0] a, input logic [1:0] op,
                        input logic [31:0] wd, input logic [1:0] pr);
    req_valid = 1'b1; req_addr = a; req_op = op; req_wdata = wd; req_priv = pr;
  endtask

  task automatic idle();
    req_valid = 1'b0; req_op = 2'b00; req_wdata = '0;
  endtask

  task automatic read_now(input logic [11:0] a, output logic [31:0] v);
    access(a, 2'b00, 32'h0, 2'b11);
    #1 v = rd_data;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t0, t1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10 reset state
    read_now(12'hB04, v); check("R10 retired count after reset", v, 32'h0);
    check("R10 gpio_out after reset", gpio_out, 32'h0);
    check("R10 gpio_oe after reset", gpio_oe, 32'h0);
    @(negedge clk);

    // vector walk: R1 R2 R3 R5 R7 R9
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][81:70], VEC[i][69:68], VEC[i][65:34], VEC[i][67:66]);
      #1;
      check($sformatf("R1/R2/R3/R9 vector %0d illegal", i), {31'b0, illegal}, {31'b0, VEC[i][33]});
      if (VEC[i][32]) check($sformatf("R7/R9/R10 vector %0d rd_data", i), rd_data, VEC[i][31:0]);
      @(negedge clk);
    end
    idle();
    check("R7 gpio_out pins", gpio_out, 32'h05A5_00FF);
    check("R7 gpio_oe pins", gpio_oe, 32'h0F0F_0F0F);

    // R4 retire counting
    retire = 1'b1;
    repeat (5) @(negedge clk);
    retire = 1'b0;
    read_now(12'hB04, v); check("R4 five retires", v, 32'd5);
    @(negedge clk);

    // R8 software write beats retire
    access(12'hB04, 2'b01, 32'h100, 2'b11); retire = 1'b1;
    @(negedge clk); retire = 1'b0;
    read_now(12'hB04, v); check("R8 write priority", v, 32'h100);
    @(negedge clk);

    // R6 clear on write intent
    access(12'hB06, 2'b10, 32'h1, 2'b11);
    #1 check("R6 clear address reads zero", rd_data, 32'h0);
    check("R6 clear access legal", {31'b0, illegal}, 32'h0);
    @(negedge clk);
    read_now(12'hB04, v); check("R6 count cleared", v, 32'h0);
    @(negedge clk);

    // R3/R6 zero-mask set on clear address is a read only
    idle(); retire = 1'b1; @(negedge clk); retire = 1'b0;
    access(12'hB06, 2'b10, 32'h0, 2'b11);
    @(negedge clk);
    read_now(12'hB04, v); check("R3 zero mask does not clear", v, 32'd1);
    @(negedge clk);

    // R2/R9 preset blocked at user privilege
    access(12'hB07, 2'b00, 32'h0, 2'b00);
    #1 check("R2 user preset illegal", {31'b0, illegal}, 32'h1);
    @(negedge clk);
    read_now(12'hB04, v); check("R9 no preset when illegal", v, 32'd1);
    @(negedge clk);

    // R6 preset on read
    access(12'hB07, 2'b00, 32'h0, 2'b11);
    #1 check("R6 preset address reads zero", rd_data, 32'h0);
    @(negedge clk);
    read_now(12'hB04, v); check("R6 preset loaded", v, 32'h4000_0000);
    @(negedge clk);

    // R5 cycle count
    read_now(12'hB05, t0);
    repeat (10) @(negedge clk);
    read_now(12'hB05, t1);
    check("R5 ten ticks", t1 - t0, 32'd10);
    @(negedge clk);

    // R10 reset clears registers
    idle(); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 gpio_out after second reset", gpio_out, 32'h0);
    read_now(12'hB09, v); check("R10 drive enable after reset", v, 32'h0);
    read_now(12'hB04, v); check("R10 count after reset", v, 32'h0);
    @(negedge clk); idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule